// File: doc/BRIEF.md
# Two-Channel Reloadable Down-Counter Timer with PWM

The block holds two 8-bit down-counters. Each counter has its own reload value, compare value and control bits. A counter steps down once for every falling edge of a separate count clock. When it steps past zero it loads its reload value again and issues a one-cycle underflow pulse. In PWM mode, a step that lands on the compare value issues a match pulse, which serves as an interrupt request, and drives the PWM output low. A reload drives the PWM output high again. Run and stop requests take effect only on a falling edge of the count clock, so a stopping channel always finishes on a decrement. A preset strobe copies the reload value into the counter whether the channel is running or stopped.

The two counters can be chained into one 16-bit timer. In that mode the upper channel steps only when the lower channel underflows, and a 16-bit underflow pulse marks the cycle in which both channels wrap together. All access goes through a 4-bit register port. A read of a channel's low count nibble takes a snapshot of the upper count bits, so that a nibble-by-nibble read returns one coherent value. In chained mode that snapshot covers the upper 12 bits.

The count clock is sampled in the system clock domain and must already be synchronous to it.

Top module: `prog_timer2`

## Requirements
- R1: Address bit 3 selects the channel (0 or 1) and bits 2:0 select the register. Offset 0/1 is the reload value, low/high nibble. Offset 2/3 is the compare value, low/high nibble. Offset 4/5 is the count, low/high nibble. Offset 6 is control: bit 0 run, bit 1 preset, bit 2 PWM enable, bit 3 reads 0. Address 7 is the mode register, with bit 0 selecting chained 16-bit operation. Address 15 reads 0. `bus_rdata` shows the addressed register in the same cycle.
- R2: After a synchronous reset, every reload, compare and count value, the control bits, the mode bit and all outputs read 0.
- R3: A control write with bit 1 set loads the reload value into the counter at that clock edge. A control write with bit 1 clear leaves the counter unchanged. Bit 1 always reads back as 0.
- R4: A preset on a stopped channel holds the loaded value until the channel runs. A preset on a running channel lets the next count-clock falling edge step down from the loaded value.
- R5: A count-clock falling edge is `cnt_clk` high at one rising edge of `clk` and low at the next. The run bit takes effect only at such an edge. After a start, the first decrement happens on the next falling edge. The falling edge that applies a stop still performs one decrement. The run bit reads 1 from the start request until the channel has actually stopped.
- R6: A running channel decrements by one per falling edge. A step from 0 loads the reload value and raises that channel's `tmr_uf` bit for exactly one `clk` cycle.
- R7: With PWM enabled, a decrement that lands on the compare value raises `tmr_cmp` for one cycle and drives `tmr_pwm` low. A reload or preset drives `tmr_pwm` high. With PWM disabled, `tmr_pwm` and `tmr_cmp` stay low.
- R8: A read strobe on a channel's low count nibble latches that channel's high nibble. Later reads of the high nibble return the latched value until the next low-nibble read.
- R9: In chained mode, channel 1 ignores its own run bit and steps exactly when channel 0 underflows. `tmr_uf16` pulses when both channels underflow at the same edge, and it never pulses outside chained mode.
- R10: In chained mode, a low-nibble read of channel 0 latches channel 0's high nibble and all 8 bits of channel 1. Reads of channel 1's count then return the latched bits.
- R11: Writes to the count addresses have no effect.
- R12: Each channel's preset loads only its own counter, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_clk | input | 1 | Count clock level, synchronous to clk |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 4 | Write data nibble |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (triggers count snapshots) |
| bus_rdata | output | 4 | Read data nibble for bus_addr |
| tmr_uf | output | 2 | Per-channel underflow pulse |
| tmr_cmp | output | 2 | Per-channel compare-match pulse |
| tmr_pwm | output | 2 | Per-channel PWM level |
| tmr_uf16 | output | 1 | Chained 16-bit underflow pulse |

## Verification
The assertions assume that `cnt_clk` is already synchronous to `clk` and that each of its levels lasts at least one `clk` cycle. Under that assumption every falling edge is seen exactly once. They also assume that a read strobe and a write strobe never target the same register in one cycle. The stimulus holds each count-clock level for a full `clk` cycle. It changes bus signals only between rising edges, and it never issues a read and a write together.

// File: rtl/tmr_pkg.sv
// Package for the two-channel timer: data widths, register offsets and control bit positions.
// Assumes exactly two channels; address bit 3 selects the channel.
package tmr_pkg;
    localparam int NW        = 4;              // bus nibble width
    localparam int CW        = 8;              // counter width per channel
    localparam int NCH       = 2;              // channel count
    localparam int AW        = 4;              // register address width
    localparam int OW        = AW - 1;         // offset width inside a channel window
    localparam int CH_STRIDE = 1 << OW;        // address distance between channels

    localparam int OFS_RLD_LO = 0;
    localparam int OFS_CMP_LO = 2;
    localparam int OFS_CNT_LO = 4;
    localparam int OFS_CNT_HI = 5;
    localparam int OFS_CTRL   = 6;
    localparam int OFS_MODE   = 7;

    localparam int CTL_RUN    = 0;
    localparam int CTL_PRESET = 1;
    localparam int CTL_PWM    = 2;
endpackage

// File: rtl/tmr_edge_det.sv
// Falling-edge detector for the count clock.
// Assumes src is synchronous to clk and each level lasts at least one clk cycle.
module tmr_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    output logic fall
);
    logic src_q;

    // Keep the previous count-clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= 1'b0;
        else        src_q <= src;
    end

    assign fall = src_q & ~src;

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R5
endmodule

// File: rtl/tmr_channel.sv
// One timer channel: reload and compare registers, run synchronisation,
// down-counter with auto-reload, compare match and PWM level.
// Assumes tick is a single-cycle pulse and that the bus offset is already decoded.
module tmr_channel #(
    parameter int CW = tmr_pkg::CW,
    parameter int NW = tmr_pkg::NW,
    parameter int OW = tmr_pkg::OW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          chained,
    input  logic          ext_step,
    input  logic          wr_en,
    input  logic          sel,
    input  logic [OW-1:0] off,
    input  logic [NW-1:0] wr_data,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] reload,
    output logic [CW-1:0] compare,
    output logic          run_rd,
    output logic          pwm_en,
    output logic          uf_now,
    output logic          uf,
    output logic          cmp,
    output logic          pwm
);
    import tmr_pkg::*;

    localparam int NSEG = CW / NW;

    logic          run_req;
    logic          run_act;
    logic          ctrl_we;
    logic          preset;
    logic          step;
    logic          dec;
    logic          hit;
    logic [CW-1:0] cnt_dec;

    assign ctrl_we = wr_en && sel && (off == OW'(OFS_CTRL));
    assign preset  = ctrl_we && wr_data[CTL_PRESET];
    assign step    = chained ? ext_step : (tick && run_act);
    assign cnt_dec = cnt - CW'(1);
    assign uf_now  = step && (cnt == '0) && !preset;
    assign dec     = step && (cnt != '0) && !preset;
    assign hit     = dec && pwm_en && (cnt_dec == compare);
    assign run_rd  = run_req | run_act;

    // Nibble writes into the reload and compare registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload  <= '0;
            compare <= '0;
        end else if (wr_en && sel) begin
            for (int k = 0; k < NSEG; k++) begin
                if (off == OW'(OFS_RLD_LO + k)) reload[k*NW +: NW]  <= wr_data;
                if (off == OW'(OFS_CMP_LO + k)) compare[k*NW +: NW] <= wr_data;
            end
        end
    end

    // Control register: requested run state and PWM enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_req <= 1'b0;
            pwm_en  <= 1'b0;
        end else if (ctrl_we) begin
            run_req <= wr_data[CTL_RUN];
            pwm_en  <= wr_data[CTL_PWM];
        end
    end

    // Effective run state follows the request only at a count-clock falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_act <= 1'b0;
        else if (tick) run_act <= run_req;
    end

    // Down-counter with preset and auto-reload.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (preset || uf_now) cnt <= reload;
        else if (dec)              cnt <= cnt_dec;
    end

    // Registered underflow and compare pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uf  <= 1'b0;
            cmp <= 1'b0;
        end else begin
            uf  <= uf_now;
            cmp <= hit;
        end
    end

    // PWM level: set on reload, cleared on compare match.
    always_ff @(posedge clk) begin
        if (!rst_n)                pwm <= 1'b0;
        else if (!pwm_en)          pwm <= 1'b0;
        else if (preset || uf_now) pwm <= 1'b1;
        else if (hit)              pwm <= 1'b0;
    end

    AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> cnt == $past(reload)); // R3
    AST_RELOAD_ON_UF: assert property (@(posedge clk) disable iff (!rst_n)
        uf_now |=> cnt == $past(reload)); // R6
    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !preset) |=> $stable(cnt)); // R4
    AST_RUN_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(run_act)); // R5
    AST_PWM_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_en |=> !pwm && !cmp); // R7
    AST_MATCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cmp |-> !pwm); // R7
    AST_UF_PWM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (uf && $past(pwm_en)) |-> pwm); // R7
endmodule

// File: rtl/tmr_snapshot.sv
// Count snapshot registers for coherent nibble reads.
// A low-nibble read of channel 0 latches its high nibble and, in chained mode,
// all of channel 1. A low-nibble read of channel 1 latches its high nibble only
// outside chained mode.
module tmr_snapshot #(
    parameter int CW = tmr_pkg::CW,
    parameter int NW = tmr_pkg::NW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_lo0,
    input  logic             rd_lo1,
    input  logic             chained,
    input  logic [CW-1:NW]   cnt0_hi,
    input  logic [CW-1:0]    cnt1,
    output logic [CW-NW-1:0] snap0_hi,
    output logic [CW-1:0]    snap1
);
    // Latch the frozen count bits on low-nibble reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap0_hi <= '0;
            snap1    <= '0;
        end else if (rd_lo0) begin
            snap0_hi <= cnt0_hi;
            if (chained) snap1 <= cnt1;
        end else if (rd_lo1 && !chained) begin
            snap1[CW-1:NW] <= cnt1[CW-1:NW];
        end
    end

    AST_SNAP0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_lo0 |=> $stable(snap0_hi)); // R8
    AST_SNAP1_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo0 && chained) |=> snap1 == $past(cnt1)); // R10
    AST_SNAP1_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_lo0 |=> $stable(snap1[NW-1:0])); // R10
endmodule

// File: rtl/prog_timer2.sv
// Two-channel programmable timer with a 4-bit register port, optional 16-bit chaining,
// underflow, compare-match and PWM outputs per channel.
// Assumes cnt_clk is synchronous to clk and that read and write never hit one register together.
module prog_timer2 (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cnt_clk,
    input  logic [3:0] bus_addr,
    input  logic [3:0] bus_wdata,
    input  logic       bus_wr,
    input  logic       bus_rd,
    output logic [3:0] bus_rdata,
    output logic [1:0] tmr_uf,
    output logic [1:0] tmr_cmp,
    output logic [1:0] tmr_pwm,
    output logic       tmr_uf16
);
    import tmr_pkg::*;

    logic           tick;
    logic           chain;
    logic [NCH-1:0] uf_now;
    logic [NCH-1:0] run_rd;
    logic [NCH-1:0] pwm_en;
    logic [CW-1:0]  cnt_a     [NCH];
    logic [CW-1:0]  reload_a  [NCH];
    logic [CW-1:0]  compare_a [NCH];
    logic [CW-NW-1:0] snap0_hi;
    logic [CW-1:0]  snap1;
    logic           rd_lo0;
    logic           rd_lo1;
    logic           ch_idx;
    logic [OW-1:0]  off;

    assign ch_idx = bus_addr[AW-1];
    assign off    = bus_addr[OW-1:0];
    assign rd_lo0 = bus_rd && (bus_addr == AW'(OFS_CNT_LO));
    assign rd_lo1 = bus_rd && (bus_addr == AW'(CH_STRIDE + OFS_CNT_LO));

    tmr_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (cnt_clk),
        .fall  (tick)
    );

    // Mode register: chained 16-bit operation.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      chain <= 1'b0;
        else if (bus_wr && bus_addr == AW'(OFS_MODE))    chain <= bus_wdata[0];
    end

    // 16-bit underflow pulse when both channels wrap at one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) tmr_uf16 <= 1'b0;
        else        tmr_uf16 <= chain && uf_now[0] && uf_now[1];
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic ext;
        logic chn;
        if (g == 0) begin : g_low
            assign ext = 1'b0;
            assign chn = 1'b0;
        end else begin : g_up
            assign ext = uf_now[g-1];
            assign chn = chain;
        end

        tmr_channel #(.CW(CW), .NW(NW), .OW(OW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .chained  (chn),
            .ext_step (ext),
            .wr_en    (bus_wr),
            .sel      (ch_idx == 1'(g)),
            .off      (off),
            .wr_data  (bus_wdata),
            .cnt      (cnt_a[g]),
            .reload   (reload_a[g]),
            .compare  (compare_a[g]),
            .run_rd   (run_rd[g]),
            .pwm_en   (pwm_en[g]),
            .uf_now   (uf_now[g]),
            .uf       (tmr_uf[g]),
            .cmp      (tmr_cmp[g]),
            .pwm      (tmr_pwm[g])
        );
    end

    tmr_snapshot #(.CW(CW), .NW(NW)) u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_lo0   (rd_lo0),
        .rd_lo1   (rd_lo1),
        .chained  (chain),
        .cnt0_hi  (cnt_a[0][CW-1:NW]),
        .cnt1     (cnt_a[1]),
        .snap0_hi (snap0_hi),
        .snap1    (snap1)
    );

    // Read multiplexer for the addressed nibble.
    always_comb begin
        bus_rdata = '0;
        case (off)
            3'd0, 3'd1: bus_rdata = reload_a[ch_idx][off[0]*NW +: NW];
            3'd2, 3'd3: bus_rdata = compare_a[ch_idx][off[0]*NW +: NW];
            3'd4: begin
                if (!ch_idx)    bus_rdata = cnt_a[0][NW-1:0];
                else if (chain) bus_rdata = snap1[NW-1:0];
                else            bus_rdata = cnt_a[1][NW-1:0];
            end
            3'd5:    bus_rdata = ch_idx ? snap1[CW-1:NW] : snap0_hi;
            3'd6:    bus_rdata = {1'b0, pwm_en[ch_idx], 1'b0, run_rd[ch_idx]};
            default: bus_rdata = ch_idx ? 4'h0 : {3'b000, chain};
        endcase
    end

    AST_UF16_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_uf16 |-> tmr_uf[0] && tmr_uf[1]); // R9
    AST_UF16_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        !chain |=> !tmr_uf16); // R9
    AST_UPPER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (chain && !uf_now[0] && !(bus_wr && bus_addr == AW'(CH_STRIDE + OFS_CTRL)))
        |=> $stable(cnt_a[1])); // R9
endmodule

// File: tb/prog_timer2_test.sv
// Bench for prog_timer2: a behavioural reference model updated at each rising edge,
// outputs compared every cycle and register reads compared on each access.
module prog_timer2_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_clk = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [3:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [3:0] bus_rdata;
    logic [1:0] tmr_uf, tmr_cmp, tmr_pwm;
    logic       tmr_uf16;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 0;

    always #5 clk = ~clk;

    prog_timer2 uut (
        .clk(clk), .rst_n(rst_n), .cnt_clk(cnt_clk),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .tmr_uf(tmr_uf), .tmr_cmp(tmr_cmp), .tmr_pwm(tmr_pwm),
        .tmr_uf16(tmr_uf16)
    );

    // Reference model state.
    bit [7:0] m_rl [2], m_cp [2], m_ct [2];
    bit       m_rq [2], m_ra [2], m_pe [2], m_pw [2], m_uf [2], m_cm [2];
    bit       m_chain, m_uf16, m_prev;
    bit [3:0] m_s0;
    bit [7:0] m_s1;
    bit       t_tick;
    bit       t_pre [2], t_stp [2], t_ufn [2], t_hit [2];
    bit [7:0] t_dec;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_rl[c] = 0; m_cp[c] = 0; m_ct[c] = 0; m_rq[c] = 0; m_ra[c] = 0;
                m_pe[c] = 0; m_pw[c] = 0; m_uf[c] = 0; m_cm[c] = 0;
            end
            m_chain = 0; m_uf16 = 0; m_prev = 0; m_s0 = 0; m_s1 = 0;
        end else begin
            t_tick = m_prev && !cnt_clk;
            m_prev = cnt_clk;
            for (int c = 0; c < 2; c++)
                t_pre[c] = bus_wr && bus_addr == {c[0], 3'd6} && bus_wdata[1];
            for (int c = 0; c < 2; c++) begin
                if (c == 1 && m_chain) t_stp[c] = t_ufn[0];
                else                   t_stp[c] = t_tick && m_ra[c];
                t_ufn[c] = t_stp[c] && m_ct[c] == 0 && !t_pre[c];
                t_dec = m_ct[c] - 8'd1;
                t_hit[c] = t_stp[c] && m_ct[c] != 0 && !t_pre[c] && m_pe[c] && t_dec == m_cp[c];
            end
            if (bus_rd && bus_addr == 4'd4) begin
                m_s0 = m_ct[0][7:4];
                if (m_chain) m_s1 = m_ct[1];
            end else if (bus_rd && bus_addr == 4'd12 && !m_chain) begin
                m_s1[7:4] = m_ct[1][7:4];
            end
            m_uf16 = m_chain && t_ufn[0] && t_ufn[1];
            for (int c = 0; c < 2; c++) begin
                m_uf[c] = t_ufn[c];
                m_cm[c] = t_hit[c];
                if (!m_pe[c])                   m_pw[c] = 0;
                else if (t_pre[c] || t_ufn[c])  m_pw[c] = 1;
                else if (t_hit[c])              m_pw[c] = 0;
                if (t_pre[c] || t_ufn[c])       m_ct[c] = m_rl[c];
                else if (t_stp[c])              m_ct[c] = m_ct[c] - 8'd1;
                if (t_tick) m_ra[c] = m_rq[c];
            end
            if (bus_wr) begin
                case (bus_addr[2:0])
                    3'd0: m_rl[bus_addr[3]][3:0] = bus_wdata;
                    3'd1: m_rl[bus_addr[3]][7:4] = bus_wdata;
                    3'd2: m_cp[bus_addr[3]][3:0] = bus_wdata;
                    3'd3: m_cp[bus_addr[3]][7:4] = bus_wdata;
                    3'd6: begin
                        m_rq[bus_addr[3]] = bus_wdata[0];
                        m_pe[bus_addr[3]] = bus_wdata[2];
                    end
                    3'd7: if (!bus_addr[3]) m_chain = bus_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [3:0] mread(input logic [3:0] a);
        logic c;
        c = a[3];
        case (a[2:0])
            3'd0: return m_rl[c][3:0];
            3'd1: return m_rl[c][7:4];
            3'd2: return m_cp[c][3:0];
            3'd3: return m_cp[c][7:4];
            3'd4: return !c ? m_ct[0][3:0] : (m_chain ? m_s1[3:0] : m_ct[1][3:0]);
            3'd5: return !c ? m_s0 : m_s1[7:4];
            3'd6: return {1'b0, m_pe[c], 1'b0, m_rq[c] | m_ra[c]};
            default: return !c ? {3'b000, m_chain} : 4'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle output comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6 underflow", {6'd0, tmr_uf}, {6'd0, m_uf[1], m_uf[0]});
            chk("R7 match", {6'd0, tmr_cmp}, {6'd0, m_cm[1], m_cm[0]});
            chk("R7 pwm", {6'd0, tmr_pwm}, {6'd0, m_pw[1], m_pw[0]});
            chk("R9 uf16", {7'd0, tmr_uf16}, {7'd0, m_uf16});
        end
    end

    task automatic wr(input logic [3:0] a, input logic [3:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        #1 chk(tag, {4'd0, bus_rdata}, {4'd0, mread(a)});
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            cnt_clk = 1'b1;
            @(negedge clk);
            cnt_clk = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic finish_run;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1, R2: reset state of every address
        for (int a = 0; a < 16; a++) rd(4'(a), "R1 R2 reset read");
        chk("R2 count lo zero", {4'd0, bus_rdata}, 8'd0);

        // R3: load channel 0 and preset it while stopped
        wr(4'd0, 4'h5); wr(4'd1, 4'h2); wr(4'd2, 4'h0); wr(4'd3, 4'h2);
        wr(4'd6, 4'b0000);
        rd(4'd4, "R3 no preset on bit1 clear");
        wr(4'd6, 4'b0010);
        rd(4'd4, "R3 preset lo"); rd(4'd5, "R3 preset hi"); rd(4'd6, "R3 preset bit reads 0");
        // R4, R5: stopped channel holds across falling edges
        ticks(3);
        rd(4'd4, "R4 stopped hold");
        // R5: start, run bit visible before it takes effect
        wr(4'd6, 4'b0101);
        rd(4'd6, "R5 run pending");
        ticks(1);
        rd(4'd4, "R5 no decrement on start edge");
        ticks(2);
        rd(4'd4, "R6 decrement");
        // R6, R7: ride through several underflows with PWM enabled
        ticks(80);
        rd(4'd4, "R6 after wrap");
        // R5: stop takes one more decrement
        wr(4'd6, 4'b0100);
        rd(4'd6, "R5 run reads 1 until stopped");
        ticks(1);
        rd(4'd6, "R5 stopped"); rd(4'd4, "R5 stop decrement");
        // R4: preset while stopped, then while running
        wr(4'd0, 4'h3); wr(4'd1, 4'h0);
        wr(4'd6, 4'b0110);
        ticks(2);
        rd(4'd4, "R4 preset held while stopped");
        wr(4'd6, 4'b0101);
        ticks(3);
        wr(4'd6, 4'b0111);
        rd(4'd4, "R4 preset while running");
        ticks(1);
        rd(4'd4, "R4 continue from reload");
        // R7: compare zero, then PWM disabled
        wr(4'd2, 4'h0); wr(4'd3, 4'h0);
        ticks(12);
        wr(4'd6, 4'b0001);
        ticks(6);
        // R11: count addresses are read-only
        wr(4'd4, 4'hF); wr(4'd5, 4'hF);
        rd(4'd4, "R11 write ignored lo"); rd(4'd5, "R11 write ignored hi");
        // R8: snapshot of the high nibble with a larger reload
        wr(4'd0, 4'h0); wr(4'd1, 4'hC); wr(4'd6, 4'b0011);
        ticks(5);
        rd(4'd4, "R8 lo read");
        ticks(20);
        rd(4'd5, "R8 frozen hi");
        rd(4'd4, "R8 lo read again"); rd(4'd5, "R8 refreshed hi");
        // R8: channel 1 unchained snapshot
        wr(4'd8, 4'h4); wr(4'd9, 4'h9); wr(4'd14, 4'b0011);
        ticks(4);
        rd(4'd12, "R8 ch1 lo"); ticks(20); rd(4'd13, "R8 ch1 frozen hi");
        wr(4'd14, 4'b0000);
        wr(4'd6, 4'b0000);
        ticks(1);
        // R9, R12: chained mode
        wr(4'd7, 4'h1);
        rd(4'd7, "R9 mode reads back");
        wr(4'd0, 4'h2); wr(4'd1, 4'h0); wr(4'd8, 4'h1); wr(4'd9, 4'h0);
        wr(4'd10, 4'h0); wr(4'd11, 4'h0);
        wr(4'd6, 4'b0010);
        wr(4'd14, 4'b0110);
        rd(4'd4, "R12 ch0 own preset"); rd(4'd12, "R12 ch1 own preset");
        wr(4'd6, 4'b0101);
        ticks(25);
        // R10: 12-bit snapshot across the chain
        rd(4'd4, "R10 chained lo");
        ticks(4);
        rd(4'd12, "R10 ch1 lo frozen"); rd(4'd13, "R10 ch1 hi frozen"); rd(4'd5, "R10 ch0 hi frozen");
        // R9: larger chained period
        wr(4'd0, 4'h0); wr(4'd8, 4'h2);
        wr(4'd6, 4'b0111); wr(4'd14, 4'b0110);
        ticks(30);
        wr(4'd7, 4'h0);
        ticks(10);
        rd(4'd7, "R9 mode cleared");
        finish_run();
    end
endmodule